// File: doc/BRIEF.md
# Programmable YCbCr-to-RGB Input Colour Converter

This block sits in front of a display plane and turns each incoming YCbCr pixel into an RGB pixel. Every channel first receives a signed pre-offset. The three offset channels are then multiplied by a 3x3 matrix whose entries are stored in a compact 16-bit sign/exponent/mantissa code. A signed post-offset is added to each output row, and the result is rounded and clamped to the 10-bit pixel range. An enable bit in the configuration turns the unit into a plain pass-through.

Configuration words arrive through a single write port. Every write lands in a pending copy of the configuration. The active copy, which the datapath uses, takes the pending values only on a frame-start pulse. This keeps a frame from being converted with a half-written matrix. Pixels enter and leave on valid/ready streams through a three-stage pipeline that stalls as a whole when the output is held.

Top module: `ycc_rgb_csc`

## Requirements
- R1: While `rst` is high and in the cycle after it, `out_valid` is 0 and `in_ready` is 1. The active configuration resets to all zeros with the enable bit clear, so the unit starts in pass-through.
- R2: When the active enable bit is 0, `out_r`, `out_g` and `out_b` equal the accepted `in_cr`, `in_y` and `in_cb` unchanged, with the same latency as converted pixels.
- R3: A coefficient word holds the sign in bit 15, a 3-bit exponent code in bits 14:12 and a 9-bit mantissa in bits 11:3. Bits 2:0 have no effect. The value is ±mantissa/2^k, where k is 7, 8, 9, 10, 11 or 12 for codes 110, 111, 000, 001, 010 and 011 respectively, so 0x7800 is 1.0.
- R4: A coefficient whose exponent code is 100 or 101 acts as zero, whatever its sign and mantissa.
- R5: Write address 2r (r = 0, 1, 2 for the R, G and B rows) carries the row's first coefficient in data bits 31:16 and its second in bits 15:0. Address 2r+1 carries the third coefficient in bits 31:16. The columns multiply Cr, Y and Cb in that order.
- R6: Addresses 6, 7 and 8 hold the pre-offsets for Cr, Y and Cb in data bits 12:0. Each is a 13-bit two's-complement value in units of 2^-12 of full scale, so 0x1800 is -0.5 and 0x1F00 is -1/16. An input pixel x counts as x/1024.
- R7: Addresses 9, 10 and 11 hold the post-offsets for R, G and B in data bits 12:0, using the same format as the pre-offsets.
- R8: Each output channel is the exact sum scaled by 1024, rounded to nearest with halves rounded up, then clamped to 0..1023.
- R9: Address 12 bit 0 is the enable bit. All writes change only the pending configuration. The active configuration copies the pending one on a `frame_start` pulse. A write in the same cycle as the pulse reaches the active copy only at the next pulse.
- R10: A pixel accepted at a rising edge, with `out_ready` held high, appears on the outputs with `out_valid` high after the second following rising edge, and not earlier.
- R11: While `out_valid` is high and `out_ready` is low, the outputs and `out_valid` hold their values and `in_ready` is low. No pixel is lost or duplicated under back-pressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| frame_start | input | 1 | Pulse that copies pending configuration to active |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_cr | input | 10 | Cr channel |
| in_y | input | 10 | Y channel |
| in_cb | input | 10 | Cb channel |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream ready |
| out_r | output | 10 | Red result |
| out_g | output | 10 | Green result |
| out_b | output | 10 | Blue result |

## Verification
An identity matrix, written with the reserved coefficient bits set, must return each pixel untouched. This separates a wrong word packing or column order from a wrong exponent decode. A standard-definition matrix with the usual chroma and luma pre-offsets, driven with black, white and saturated corner pixels, exercises rounding and both clamp limits. A matrix that places a different exponent code and sign in each cell, followed by one built only from the zero codes and non-zero post-offsets, isolates the exponent table and the post-offset path. Streams under random back-pressure, and a write that coincides with the frame pulse, check stall holding and the pending-to-active timing.

// File: rtl/csc_pkg.sv
package csc_pkg;

  localparam int COEF_W = 16;
  localparam int MANT_W = 9;
  localparam int N_CH   = 3;
  localparam int N_COEF = N_CH * N_CH;

  typedef struct packed {
    logic              neg;
    logic              nil;
    logic [2:0]        shl;
    logic [MANT_W-1:0] mag;
  } coef_dec_t;

  // shl is the left shift that brings mantissa/2^k to units of 2^-12
  function automatic coef_dec_t coef_decode(input logic [COEF_W-1:0] c);
    coef_dec_t d;
    d.neg = c[15];
    d.mag = c[11:3];
    d.nil = 1'b0;
    case (c[14:12])
      3'b110:  d.shl = 3'd5;
      3'b111:  d.shl = 3'd4;
      3'b000:  d.shl = 3'd3;
      3'b001:  d.shl = 3'd2;
      3'b010:  d.shl = 3'd1;
      3'b011:  d.shl = 3'd0;
      default: begin
        d.shl = 3'd0;
        d.nil = 1'b1;
      end
    endcase
    return d;
  endfunction

endpackage

// File: rtl/csc_cfg_bank.sv
module csc_cfg_bank
  import csc_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              frame_start,
  output logic [COEF_W-1:0] coef_o [N_COEF],
  output logic [OFF_W-1:0]  pre_o  [N_CH],
  output logic [OFF_W-1:0]  post_o [N_CH],
  output logic              en_o
);

  localparam int HI_LSB = DATA_W - COEF_W;

  logic [COEF_W-1:0] coef_p [N_COEF];
  logic [OFF_W-1:0]  pre_p  [N_CH];
  logic [OFF_W-1:0]  post_p [N_CH];
  logic              en_p;

  logic [COEF_W-1:0] w_hi, w_lo;
  logic [OFF_W-1:0]  w_off;
  assign w_hi  = wdata[DATA_W-1:HI_LSB];
  assign w_lo  = wdata[COEF_W-1:0];
  assign w_off = wdata[OFF_W-1:0];

  // pending copy: written from the port
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_COEF; i++) coef_p[i] <= '0;
      for (int i = 0; i < N_CH; i++) begin
        pre_p[i]  <= '0;
        post_p[i] <= '0;
      end
      en_p <= 1'b0;
    end else if (we) begin
      case (int'(addr))
        0:  begin coef_p[0] <= w_hi; coef_p[1] <= w_lo; end
        1:  coef_p[2] <= w_hi;
        2:  begin coef_p[3] <= w_hi; coef_p[4] <= w_lo; end
        3:  coef_p[5] <= w_hi;
        4:  begin coef_p[6] <= w_hi; coef_p[7] <= w_lo; end
        5:  coef_p[8] <= w_hi;
        6:  pre_p[0]  <= w_off;
        7:  pre_p[1]  <= w_off;
        8:  pre_p[2]  <= w_off;
        9:  post_p[0] <= w_off;
        10: post_p[1] <= w_off;
        11: post_p[2] <= w_off;
        12: en_p      <= wdata[0];
        default: ;
      endcase
    end
  end

  // active copy: follows pending only on the frame pulse
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_COEF; i++) coef_o[i] <= '0;
      for (int i = 0; i < N_CH; i++) begin
        pre_o[i]  <= '0;
        post_o[i] <= '0;
      end
      en_o <= 1'b0;
    end else if (frame_start) begin
      coef_o <= coef_p;
      pre_o  <= pre_p;
      post_o <= post_p;
      en_o   <= en_p;
    end
  end

  assert_active_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> $stable(en_o) && $stable(coef_o[0]) && $stable(pre_o[1])
                     && $stable(post_o[2]));

endmodule

// File: rtl/csc_term.sv
module csc_term
  import csc_pkg::*;
#(
  parameter int PRE_W = 15,
  parameter int ACC_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ce,
  input  logic signed [PRE_W-1:0] p,
  input  logic [COEF_W-1:0]       c,
  output logic signed [ACC_W-1:0] t
);

  coef_dec_t d;
  logic signed [ACC_W-1:0] p_x, m_x, prod;

  assign d    = coef_decode(c);
  assign p_x  = {{(ACC_W-PRE_W){p[PRE_W-1]}}, p};
  assign m_x  = $signed({{(ACC_W-MANT_W){1'b0}}, d.mag}) <<< d.shl;
  assign prod = p_x * m_x;

  always_ff @(posedge clk) begin
    if (rst)     t <= '0;
    else if (ce) t <= d.nil ? '0 : (d.neg ? -prod : prod);
  end

  assert_zero_code_R4: assert property (@(posedge clk) disable iff (rst)
    (ce && c[14:13] == 2'b10) |=> (t == '0));

endmodule

// File: rtl/csc_out_chan.sv
module csc_out_chan #(
  parameter int PIX_W = 10,
  parameter int OFF_W = 13,
  parameter int ACC_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ce,
  input  logic                    en,
  input  logic signed [ACC_W-1:0] t0,
  input  logic signed [ACC_W-1:0] t1,
  input  logic signed [ACC_W-1:0] t2,
  input  logic [OFF_W-1:0]        post,
  input  logic [PIX_W-1:0]        pix,
  output logic [PIX_W-1:0]        q
);

  localparam int FRAC_W = OFF_W - 1;
  localparam int DROP   = 2 * FRAC_W - PIX_W;
  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) <<< (DROP - 1);
  localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((1 << PIX_W) - 1);

  logic signed [ACC_W-1:0] post_x, sum, rnd, shr;
  logic [PIX_W-1:0] sat;

  assign post_x = $signed({{(ACC_W-OFF_W-FRAC_W){post[OFF_W-1]}}, post, {FRAC_W{1'b0}}});
  assign sum    = t0 + t1 + t2 + post_x;
  assign rnd    = sum + HALF;
  assign shr    = rnd >>> DROP;

  always_comb begin
    if (shr < 0)         sat = '0;
    else if (shr > MAXV) sat = '1;
    else                 sat = shr[PIX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (ce) q <= en ? sat : pix;
  end

  assert_floor_R8: assert property (@(posedge clk) disable iff (rst)
    (ce && en && sum < 0) |=> (q == '0));

  assert_bypass_R2: assert property (@(posedge clk) disable iff (rst)
    (ce && !en) |=> (q == $past(pix)));

endmodule

// File: rtl/ycc_rgb_csc.sv
module ycc_rgb_csc
  import csc_pkg::*;
#(
  parameter int PIX_W  = 10,
  parameter int OFF_W  = 13,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              frame_start,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PIX_W-1:0]  in_cr,
  input  logic [PIX_W-1:0]  in_y,
  input  logic [PIX_W-1:0]  in_cb,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PIX_W-1:0]  out_r,
  output logic [PIX_W-1:0]  out_g,
  output logic [PIX_W-1:0]  out_b
);

  localparam int FRAC_W = OFF_W - 1;
  localparam int UP     = FRAC_W - PIX_W;
  localparam int PRE_W  = FRAC_W + 3;
  localparam int ACC_W  = PRE_W + MANT_W + 8;

  logic [COEF_W-1:0] coef [N_COEF];
  logic [OFF_W-1:0]  pre  [N_CH];
  logic [OFF_W-1:0]  post [N_CH];
  logic              en_cfg;

  csc_cfg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .frame_start(frame_start), .coef_o(coef), .pre_o(pre), .post_o(post),
    .en_o(en_cfg)
  );

  // whole pipeline advances together
  logic adv;
  logic s1_v, s2_v, s3_v;
  assign adv      = !s3_v || out_ready;
  assign in_ready = adv;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0;
      s2_v <= 1'b0;
      s3_v <= 1'b0;
    end else if (adv) begin
      s1_v <= in_valid;
      s2_v <= s1_v;
      s3_v <= s2_v;
    end
  end

  // stage 1: pre-offset (columns Cr, Y, Cb)
  logic [PIX_W-1:0]        lane_in [N_CH];
  logic signed [PRE_W-1:0] s1_p    [N_CH];
  logic [PIX_W-1:0]        s1_pix  [N_CH];
  logic [PIX_W-1:0]        s2_pix  [N_CH];
  logic                    s1_en, s2_en;

  assign lane_in[0] = in_cr;
  assign lane_in[1] = in_y;
  assign lane_in[2] = in_cb;

  for (genvar j = 0; j < N_CH; j++) begin : g_pre
    always_ff @(posedge clk) begin
      if (rst) begin
        s1_p[j]   <= '0;
        s1_pix[j] <= '0;
        s2_pix[j] <= '0;
      end else if (adv) begin
        s1_p[j]   <= $signed({{(PRE_W-FRAC_W){1'b0}}, lane_in[j], {UP{1'b0}}})
                   + $signed({{(PRE_W-OFF_W){pre[j][OFF_W-1]}}, pre[j]});
        s1_pix[j] <= lane_in[j];
        s2_pix[j] <= s1_pix[j];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_en <= 1'b0;
      s2_en <= 1'b0;
    end else if (adv) begin
      s1_en <= en_cfg;
      s2_en <= s1_en;
    end
  end

  // stage 2: nine products
  logic signed [ACC_W-1:0] term [N_COEF];

  for (genvar r = 0; r < N_CH; r++) begin : g_row
    for (genvar c = 0; c < N_CH; c++) begin : g_col
      csc_term #(.PRE_W(PRE_W), .ACC_W(ACC_W)) u_term (
        .clk(clk), .rst(rst), .ce(adv), .p(s1_p[c]), .c(coef[r*N_CH+c]),
        .t(term[r*N_CH+c])
      );
    end
  end

  // stage 3: sum, post-offset, round, clamp or bypass
  logic [PIX_W-1:0] res [N_CH];

  for (genvar r = 0; r < N_CH; r++) begin : g_out
    csc_out_chan #(.PIX_W(PIX_W), .OFF_W(OFF_W), .ACC_W(ACC_W)) u_chan (
      .clk(clk), .rst(rst), .ce(adv), .en(s2_en),
      .t0(term[r*N_CH]), .t1(term[r*N_CH+1]), .t2(term[r*N_CH+2]),
      .post(post[r]), .pix(s2_pix[r]), .q(res[r])
    );
  end

  assign out_valid = s3_v;
  assign out_r     = res[0];
  assign out_g     = res[1];
  assign out_b     = res[2];

  assert_stall_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> out_valid && $stable(out_r) && $stable(out_g)
                                  && $stable(out_b));

  assert_accept_when_empty_R11: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);

  assert_no_early_out_R10: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && !$past(s1_v)) |=> !out_valid || $past(s2_v));

endmodule

// File: tb/ycc_rgb_csc_test.sv
module ycc_rgb_csc_test;

  localparam int CLK_PER = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        frame_start = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [9:0]  in_cr = '0, in_y = '0, in_cb = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [9:0]  out_r, out_g, out_b;

  always #(CLK_PER/2) clk = ~clk;

  ycc_rgb_csc uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .frame_start(frame_start), .in_valid(in_valid),
    .in_ready(in_ready), .in_cr(in_cr), .in_y(in_y), .in_cb(in_cb),
    .out_valid(out_valid), .out_ready(out_ready), .out_r(out_r),
    .out_g(out_g), .out_b(out_b)
  );

  int total = 0;
  int bad   = 0;

  typedef struct {
    int    r;
    int    g;
    int    b;
    string tag;
  } item_t;
  item_t sb[$];

  // configuration model
  int pend_c [9], act_c [9];
  int pend_pre [3], act_pre [3], pend_post [3], act_post [3];
  int pend_en, act_en;

  bit ready_rand = 1'b0;

  task automatic check(input string tag, input bit ok, input string act, input string exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%s expected=%s", tag, act, exp);
    end
  endtask

  function automatic int sx13(input int v);
    int w;
    w = v & 8191;
    return (w >= 4096) ? w - 8192 : w;
  endfunction

  // coefficient value in units of 2^-12 (R3, R4)
  function automatic longint coef_val(input int c);
    int e, m, sh;
    e = (c >> 12) & 7;
    m = (c >> 3) & 511;
    case (e)
      6: sh = 5;
      7: sh = 4;
      0: sh = 3;
      1: sh = 2;
      2: sh = 1;
      3: sh = 0;
      default: return 0;
    endcase
    return ((c >> 15) & 1) ? -(longint'(m) << sh) : (longint'(m) << sh);
  endfunction

  function automatic int row_out(input int row, input int cr, input int y, input int cb);
    int px [3];
    longint acc, v;
    px[0] = cr; px[1] = y; px[2] = cb;
    if (act_en == 0) return px[row];
    acc = 0;
    for (int c = 0; c < 3; c++)
      acc += longint'(px[c] * 4 + sx13(act_pre[c])) * coef_val(act_c[row*3+c]);
    acc += longint'(sx13(act_post[row])) * 4096;
    v = (acc + 8192) >>> 14;
    if (v < 0) v = 0;
    if (v > 1023) v = 1023;
    return int'(v);
  endfunction

  function automatic void model_write(input int a, input int d);
    int hi, lo;
    hi = (d >> 16) & 16'hFFFF;
    lo = d & 16'hFFFF;
    if (a < 6) begin
      if (a % 2 == 0) begin
        pend_c[(a/2)*3]   = hi;
        pend_c[(a/2)*3+1] = lo;
      end else pend_c[(a/2)*3+2] = hi;
    end else if (a < 9)  pend_pre[a-6]  = d & 8191;
    else if (a < 12)     pend_post[a-9] = d & 8191;
    else if (a == 12)    pend_en        = d & 1;
  endfunction

  function automatic void model_frame();
    act_c = pend_c; act_pre = pend_pre; act_post = pend_post; act_en = pend_en;
  endfunction

  task automatic cfg_write(input int a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 32'(d);
    @(posedge clk);
    #1 cfg_we = 1'b0;
    model_write(a, d);
  endtask

  task automatic drain();
    wait (sb.size() == 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic frame();
    drain();
    @(negedge clk);
    frame_start = 1'b1;
    @(posedge clk);
    #1 frame_start = 1'b0;
    model_frame();
  endtask

  // R9: write coinciding with the frame pulse
  task automatic write_with_frame(input int a, input int d);
    drain();
    @(negedge clk);
    frame_start = 1'b1; cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 32'(d);
    @(posedge clk);
    #1 begin frame_start = 1'b0; cfg_we = 1'b0; end
    model_frame();
    model_write(a, d);
  endtask

  task automatic send(input int cr, input int y, input int cb, input string tag);
    item_t it;
    bit took;
    @(negedge clk);
    in_valid = 1'b1; in_cr = 10'(cr); in_y = 10'(y); in_cb = 10'(cb);
    forever begin
      #1 took = in_ready;
      @(posedge clk);
      if (took) break;
      @(negedge clk);
    end
    it.r = row_out(0, cr, y, cb);
    it.g = row_out(1, cr, y, cb);
    it.b = row_out(2, cr, y, cb);
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic load_matrix(input int m [9]);
    for (int r = 0; r < 3; r++) begin
      cfg_write(2*r,   (m[r*3] << 16) | m[r*3+1]);
      cfg_write(2*r+1, m[r*3+2] << 16);
    end
  endtask

  // monitor / scoreboard
  logic [7:0] lfsr = 8'hA5;
  bit held = 1'b0;
  logic [29:0] held_val;

  initial begin
    forever begin
      @(negedge clk);
      if (held)
        check("R11 hold", out_valid && {out_r, out_g, out_b} == held_val,
              $sformatf("v=%0b %h", out_valid, {out_r, out_g, out_b}),
              $sformatf("v=1 %h", held_val));
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready = ready_rand ? (lfsr[1:0] != 2'b00) : 1'b1;
      #2;
      if (out_valid && out_ready && !rst) begin
        if (sb.size() == 0)
          check("R11 extra output", 1'b0, "output", "none");
        else begin
          item_t e;
          e = sb.pop_front();
          check(e.tag, out_r == e.r && out_g == e.g && out_b == e.b,
                $sformatf("%0d/%0d/%0d", out_r, out_g, out_b),
                $sformatf("%0d/%0d/%0d", e.r, e.g, e.b));
        end
      end
      held = out_valid && !out_ready && !rst;
      held_val = {out_r, out_g, out_b};
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int ident [9];
    int bt601 [9];
    int sweep [9];
    int nilm [9];
    for (int i = 0; i < 9; i++) begin
      pend_c[i] = 0; act_c[i] = 0;
    end
    for (int i = 0; i < 3; i++) begin
      pend_pre[i] = 0; act_pre[i] = 0; pend_post[i] = 0; act_post[i] = 0;
    end
    pend_en = 0; act_en = 0;

    repeat (3) @(posedge clk);
    #1;
    check("R1 reset valid", out_valid == 1'b0, $sformatf("%0b", out_valid), "0");
    check("R1 reset ready", in_ready == 1'b1, $sformatf("%0b", in_ready), "1");
    @(negedge clk) rst = 1'b0;
    #1;
    check("R1 after reset", out_valid == 1'b0 && in_ready == 1'b1,
          $sformatf("%0b%0b", out_valid, in_ready), "01");

    // R1/R2: reset configuration is pass-through
    send(11, 522, 1023, "R2 bypass after reset");
    send(0, 1, 2, "R2 bypass low");
    idle();

    // R3/R5: identity with reserved bits set; R9: not yet active
    ident = '{32'h7807, 0, 0, 0, 32'h7805, 0, 0, 0, 32'h7801};
    load_matrix(ident);
    for (int i = 6; i < 12; i++) cfg_write(i, 0);
    cfg_write(12, 1);
    send(300, 200, 100, "R9 pending not active");
    idle();
    frame();
    send(100, 200, 300, "R5 identity packing");
    send(1023, 0, 512, "R3 reserved bits ignored");
    send(7, 1000, 64, "R3 identity");
    idle();

    // R10: latency with ready high
    drain();
    send(5, 6, 7, "R10 latency data");
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 after edge k", out_valid == 1'b0, $sformatf("%0b", out_valid), "0");
    @(negedge clk);
    check("R10 after edge k+1", out_valid == 1'b0, $sformatf("%0b", out_valid), "0");
    @(negedge clk);
    check("R10 after edge k+2", out_valid == 1'b1, $sformatf("%0b", out_valid), "1");

    // R6/R8: standard-definition matrix with chroma/luma pre-offsets
    bt601 = '{32'h7AF8, 32'h7800, 0, 32'h8B28, 32'h7800, 32'h9AC0, 0, 32'h7800, 32'h7DD8};
    load_matrix(bt601);
    cfg_write(6, 32'h1800);
    cfg_write(7, 32'h1F00);
    cfg_write(8, 32'h1800);
    frame();
    send(512, 64, 512, "R6 black");
    send(512, 940, 512, "R6 white");
    send(512, 0, 512, "R8 clamp low");
    send(1023, 1023, 1023, "R8 clamp high");
    send(0, 0, 0, "R8 corner zero");
    send(1023, 500, 0, "R8 saturated red");
    send(0, 500, 1023, "R8 saturated blue");
    send(600, 333, 421, "R8 rounding");
    idle();

    // R3/R7: every exponent code and sign, non-zero post-offsets
    sweep = '{32'h6808, 32'h0FF8, 32'h1800, 32'h2AA8, 32'h3FF8, 32'hF800,
              32'hC100, 32'h5FF8, 32'h7800};
    load_matrix(sweep);
    for (int i = 6; i < 9; i++) cfg_write(i, 0);
    cfg_write(9, 32'h0100);
    cfg_write(10, 32'h1F00);
    cfg_write(11, 32'h0400);
    frame();
    send(200, 300, 400, "R3 exponent sweep");
    send(1023, 1023, 1023, "R3 exponent sweep max");
    send(9, 700, 3, "R7 post-offset");
    idle();

    // R4: only zero codes; output is post-offset 0.25 -> 256
    nilm = '{32'h4FF8, 32'h5FF8, 32'hCFF8, 32'hDFF8, 32'h4008, 32'h5000,
             32'hC000, 32'h4800, 32'h5FFF};
    load_matrix(nilm);
    cfg_write(9, 32'h0400);
    cfg_write(10, 32'h0400);
    cfg_write(11, 32'h0400);
    frame();
    send(1023, 1023, 1023, "R4 zero codes");
    idle();
    drain();
    check("R4 model value", row_out(0, 5, 5, 5) == 256,
          $sformatf("%0d", row_out(0, 5, 5, 5)), "256");

    // R11: random back-pressure on a stream
    load_matrix(bt601);
    cfg_write(9, 0); cfg_write(10, 0); cfg_write(11, 0);
    frame();
    ready_rand = 1'b1;
    for (int i = 0; i < 60; i++)
      send($urandom_range(0, 1023), $urandom_range(0, 1023), $urandom_range(0, 1023),
           "R11 stream");
    idle();
    drain();
    ready_rand = 1'b0;

    // R9: disable written in the same cycle as the pulse
    write_with_frame(12, 0);
    send(640, 480, 320, "R9 write with pulse");
    idle();
    frame();
    send(640, 480, 320, "R2 bypass after disable");
    idle();
    drain();

    check("R11 all outputs seen", sb.size() == 0, $sformatf("%0d", sb.size()), "0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule